// File: doc/BRIEF.md
# SDRAM Mode Register and Read Latency Pipeline

This block models the device side of a single-bank synchronous DRAM. It works at the level of commands and clock edges, and it is written as synthesizable logic. A two-bit command bus is sampled on every rising clock edge. A load-mode command stores the burst length, the CAS latency, the operating mode and the write-burst policy, all taken from the low ten address bits. READ and WRITE commands then walk a small column array in bursts. The burst address moves up by one per beat and wraps inside the aligned block whose size is the burst length.

Read words leave through a latency pipeline whose tap is chosen by the programmed CAS latency. The data-drive enable goes high one clock before the first read word is valid. It falls on the clock edge at which the last read word stops being valid.

The block also guards against bad mode settings. A load-mode command with an unsupported latency code, or with a non-normal operating mode, raises an error flag, and READ and WRITE commands have no effect while that flag is set. Any command that arrives while a burst or the pipeline drain is still in progress is dropped.

Top module: `sdr_mode_lat_core`

## Requirements
- R1: After reset, `rvalid`, `dq_oe` and `mode_err` are 0. The defaults are a burst length of 1 and a latency of 2, so a READ issued with no prior load-mode command returns one word two edges later.
- R2: The READ command is `cmd`=2'b10 and the load-mode code for a latency of 2 is 3'b010 in `addr[6:4]`. With a latency of 2, a READ sampled at edge n gives `rvalid`=1 with the first word on `rdata` from edge n+2 onward.
- R3: The load-mode code for a latency of 3 is 3'b011 in `addr[6:4]`. With a latency of 3, the first read word is valid from edge n+3 onward.
- R4: `dq_oe` rises at edge n+latency−1, one edge before the first valid read word, and it stays high for as long as `rvalid` is high.
- R5: `dq_oe` falls at the same edge as `rvalid`, which is one cycle after the last read word.
- R6: The load-mode command is `cmd`=2'b01. Burst-length codes in `addr[2:0]` are 000=1, 001=2, 010=4 and 011=8. Codes 1xx are reserved and give a burst length of 1.
- R7: Burst beat k reads or writes column (start & ~(BL−1)) | ((start+k) & (BL−1)), so a burst wraps inside its aligned block.
- R8: The WRITE command is `cmd`=2'b11. With `addr[9]`=0, a WRITE stores BL words. Beat 0 takes `wdata` at the command edge, and each later beat takes `wdata` at the edge that follows.
- R9: With `addr[9]`=1 at load-mode, a WRITE stores only the word at its start column, while READs still return BL words.
- R10: A load-mode command whose latency code is neither 010 nor 011 sets `mode_err` to 1.
- R11: A load-mode command with `addr[8:7]` not equal to 2'b00 sets `mode_err` to 1.
- R12: While `mode_err` is 1, a READ causes no `dq_oe` and no `rvalid`, and a WRITE leaves the array unchanged.
- R13: A load-mode command with a legal latency code and `addr[8:7]`=2'b00 clears `mode_err` and applies its fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register and command sample uses its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Command: 00 idle, 01 load mode, 10 READ, 11 WRITE |
| addr | input | ADDR_W | Mode fields on a load-mode command; start column on READ and WRITE |
| wdata | input | DATA_W | Write word, sampled on each write beat edge |
| rdata | output | DATA_W | Read word; zero when `rvalid` is low |
| rvalid | output | 1 | Read word on `rdata` is valid |
| dq_oe | output | 1 | Data-drive enable |
| mode_err | output | 1 | Last load-mode command was illegal |

## Verification
Assertions check the relation between drive and data on every cycle: `dq_oe` leads the first valid word and covers every word, and it falls together with `rvalid`. They also check that a rising drive edge traces back to a READ exactly latency−1 cycles before that edge, that consecutive burst columns step by one inside the aligned block, that the stored latency is always 2 or 3, and that an illegal latency code raises the error flag. What needs the bench's scenarios is the content of the data: which word arrives on which beat, whether single-location writes left neighbouring columns alone, and whether a WRITE dropped under the error flag really left the array unchanged. Only reading the array back after the fact can show these.

// File: rtl/sdr_mode_pkg.sv
`timescale 1ns/1ps
package sdr_mode_pkg;

   typedef enum logic [1:0] {
      CMD_IDLE  = 2'b00,
      CMD_MODE  = 2'b01,
      CMD_READ  = 2'b10,
      CMD_WRITE = 2'b11
   } sdr_cmd_e;

   localparam int BEAT_W  = 4;   // holds burst counts up to 8
   localparam int LAT_MAX = 3;

   // burst-length code to beat count; reserved codes fall back to one beat
   function automatic logic [BEAT_W-1:0] beats_of(input logic [2:0] code);
      case (code)
         3'b001:  return 4'd2;
         3'b010:  return 4'd4;
         3'b011:  return 4'd8;
         default: return 4'd1;
      endcase
   endfunction

   function automatic logic lat_code_ok(input logic [2:0] code);
      return (code == 3'b010) || (code == 3'b011);
   endfunction

endpackage

// File: rtl/sdr_mode_reg.sv
`timescale 1ns/1ps
module sdr_mode_reg
   import sdr_mode_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [2:0]        bl_code,
   input  logic [2:0]        lat_code,
   input  logic [1:0]        op_code,
   input  logic              single_wr_bit,
   output logic [BEAT_W-1:0] burst_len,
   output logic [1:0]        cas_lat,
   output logic              single_wr,
   output logic              mode_err
);

   logic legal;
   assign legal = lat_code_ok(lat_code) && (op_code == 2'b00);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         burst_len <= 4'd1;
         cas_lat   <= 2'd2;
         single_wr <= 1'b0;
         mode_err  <= 1'b0;
      end else if (load) begin
         if (legal) begin
            burst_len <= beats_of(bl_code);
            cas_lat   <= lat_code[1:0];
            single_wr <= single_wr_bit;
            mode_err  <= 1'b0;
         end else begin
            mode_err  <= 1'b1;
         end
      end
   end

   assert_lat_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_lat == 2'd2) || (cas_lat == 2'd3));

   assert_len_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(burst_len) == 1);

   assert_bad_lat_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !lat_code_ok(lat_code)) |=> mode_err);

endmodule

// File: rtl/sdr_burst_ctr.sv
`timescale 1ns/1ps
module sdr_burst_ctr #(
   parameter int COL_W = 4,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [COL_W-1:0] start,
   input  logic [2:0]       first_off,
   input  logic [CNT_W-1:0] beats,
   input  logic [2:0]       wrap_mask,
   output logic [COL_W-1:0] col,
   output logic             active
);

   logic [COL_W-1:0] start_q;
   logic [2:0]       off_q;
   logic [CNT_W-1:0] left_q;
   logic [2:0]       sum_lo;

   assign active = (left_q != '0);
   assign sum_lo = start_q[2:0] + off_q;
   assign col    = {start_q[COL_W-1:3], (start_q[2:0] & ~wrap_mask) | (sum_lo & wrap_mask)};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         off_q   <= '0;
         left_q  <= '0;
      end else if (load) begin
         start_q <= start;
         off_q   <= first_off;
         left_q  <= beats;
      end else if (active) begin
         off_q   <= off_q + 3'd1;
         left_q  <= left_q - 1'b1;
      end
   end

   assert_step_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |->
         ((((col[2:0] - $past(col[2:0])) & wrap_mask) == 3'd1) &&
          (col[COL_W-1:3] == $past(col[COL_W-1:3]))));

endmodule

// File: rtl/sdr_lat_pipe.sv
`timescale 1ns/1ps
module sdr_lat_pipe #(
   parameter int DATA_W    = 16,
   parameter int MAX_LAT   = 3,
   parameter bit HOLD_IDLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_v,
   input  logic [DATA_W-1:0] in_d,
   input  logic [1:0]        cas_lat,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid,
   output logic              oe,
   output logic              pending
);

   if (MAX_LAT < 3) begin : g_bad_depth
      $error("sdr_lat_pipe: MAX_LAT must be at least 3");
   end

   logic [MAX_LAT:1]  v_q;
   logic [DATA_W-1:0] d_q [1:MAX_LAT];
   logic [DATA_W-1:0] tap_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q <= '0;
         for (int s = 1; s <= MAX_LAT; s++) d_q[s] <= '0;
      end else begin
         v_q[1] <= in_v;
         d_q[1] <= in_d;
         for (int s = 2; s <= MAX_LAT; s++) begin
            v_q[s] <= v_q[s-1];
            d_q[s] <= d_q[s-1];
         end
      end
   end

   always_comb begin
      rvalid = 1'b0;
      oe     = 1'b0;
      tap_d  = '0;
      for (int s = 2; s <= MAX_LAT; s++) begin
         if (int'(cas_lat) == s) begin
            rvalid = v_q[s];
            oe     = v_q[s] | v_q[s-1];
            tap_d  = d_q[s];
         end
      end
   end

   if (HOLD_IDLE) begin : g_raw_out
      assign rdata = tap_d;
   end else begin : g_zero_out
      assign rdata = rvalid ? tap_d : '0;
   end

   assign pending = |v_q;

   assert_drive_leads_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rvalid) |-> $past(oe));

   assert_drive_covers_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |-> oe);

   assert_drive_trails_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rvalid) |-> !oe);

endmodule

// File: rtl/sdr_mode_lat_core.sv
`timescale 1ns/1ps
module sdr_mode_lat_core
   import sdr_mode_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int COL_W  = 4,
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid,
   output logic              dq_oe,
   output logic              mode_err
);

   localparam int DEPTH = 1 << COL_W;

   if (COL_W < 4) begin : g_bad_col
      $error("sdr_mode_lat_core: COL_W must be at least 4");
   end
   if (ADDR_W < 10 || ADDR_W < COL_W) begin : g_bad_addr
      $error("sdr_mode_lat_core: ADDR_W must hold the mode fields and a column");
   end

   sdr_cmd_e          cmd_e;
   logic [BEAT_W-1:0] burst_len;
   logic [1:0]        cas_lat;
   logic              single_wr;
   logic              busy, pend, ctr_active;
   logic              mode_go, rd_go, wr_go, wr_mode_q;
   logic [COL_W-1:0]  ctr_col;
   logic [BEAT_W-1:0] load_beats;
   logic [2:0]        wrap_mask;
   logic [DATA_W-1:0] mem [DEPTH];

   assign cmd_e   = sdr_cmd_e'(cmd);
   assign busy    = ctr_active | pend;
   assign mode_go = (cmd_e == CMD_MODE)  && !busy;
   assign rd_go   = (cmd_e == CMD_READ)  && !busy && !mode_err;
   assign wr_go   = (cmd_e == CMD_WRITE) && !busy && !mode_err;

   assign wrap_mask  = 3'(burst_len - 4'd1);
   assign load_beats = rd_go ? burst_len : (single_wr ? 4'd0 : burst_len - 4'd1);

   sdr_mode_reg u_mode (
      .clk           (clk),
      .rst_n         (rst_n),
      .load          (mode_go),
      .bl_code       (addr[2:0]),
      .lat_code      (addr[6:4]),
      .op_code       (addr[8:7]),
      .single_wr_bit (addr[9]),
      .burst_len     (burst_len),
      .cas_lat       (cas_lat),
      .single_wr     (single_wr),
      .mode_err      (mode_err)
   );

   sdr_burst_ctr #(.COL_W(COL_W), .CNT_W(BEAT_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (rd_go | wr_go),
      .start     (addr[COL_W-1:0]),
      .first_off (rd_go ? 3'd0 : 3'd1),
      .beats     (load_beats),
      .wrap_mask (wrap_mask),
      .col       (ctr_col),
      .active    (ctr_active)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                 wr_mode_q <= 1'b0;
      else if (rd_go || wr_go)    wr_mode_q <= wr_go;
   end

   always_ff @(posedge clk) begin
      if (wr_go)                        mem[addr[COL_W-1:0]] <= wdata;
      else if (ctr_active && wr_mode_q) mem[ctr_col]         <= wdata;
   end

   sdr_lat_pipe #(.DATA_W(DATA_W), .MAX_LAT(LAT_MAX), .HOLD_IDLE(1'b0)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_v    (ctr_active && !wr_mode_q),
      .in_d    (mem[ctr_col]),
      .cas_lat (cas_lat),
      .rdata   (rdata),
      .rvalid  (rvalid),
      .oe      (dq_oe),
      .pending (pend)
   );

   assert_lat_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dq_oe) && cas_lat == 2'd2) |-> $past(rd_go, 2));

   assert_lat_three_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dq_oe) && cas_lat == 2'd3) |-> $past(rd_go, 3));

   assert_err_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_err && !busy && (cmd_e == CMD_READ || cmd_e == CMD_WRITE)) |=> !ctr_active);

endmodule

// File: tb/sdr_mode_lat_core_bench.sv
`timescale 1ns/1ps
module sdr_mode_lat_core_bench;

   localparam int DW = 16;
   localparam int CW = 4;
   localparam int AW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cmd = 2'b00;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rvalid, dq_oe, mode_err;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] model [16];

   always #2 clk = ~clk;

   sdr_mode_lat_core #(.DATA_W(DW), .COL_W(CW), .ADDR_W(AW)) u_sdr_mode_lat_core (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rvalid(rvalid), .dq_oe(dq_oe), .mode_err(mode_err)
   );

   // {bl_code[2:0], latency[1:0], start col[3:0], expected beats[3:0]}
   localparam logic [12:0] VEC [8] = '{
      {3'b001, 2'd2, 4'd5,  4'd2},
      {3'b010, 2'd3, 4'd6,  4'd4},
      {3'b011, 2'd2, 4'd11, 4'd8},
      {3'b011, 2'd3, 4'd3,  4'd8},
      {3'b000, 2'd3, 4'd9,  4'd1},
      {3'b100, 2'd2, 4'd4,  4'd1},
      {3'b111, 2'd3, 4'd13, 4'd1},
      {3'b010, 2'd2, 4'd14, 4'd4}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int wcol(input int col, input int k, input int bl);
      int m = bl - 1;
      return (col & ~7) | ((col & 7 & ~m) | (((col & 7) + k) & m));
   endfunction

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic load_mode(input logic [2:0] blc, input logic [2:0] latc,
                            input logic [1:0] op, input logic wb);
      cmd = 2'b01;
      addr = '0;
      addr[2:0] = blc; addr[6:4] = latc; addr[8:7] = op; addr[9] = wb;
      idle(1);
      cmd = 2'b00;
      idle(2);
   endtask

   task automatic write_burst(input int col, input logic [DW-1:0] base, input int bl,
                              input bit single, input bit ignored);
      cmd = 2'b11; addr = AW'(col); wdata = base;
      idle(1);
      cmd = 2'b00;
      for (int k = 1; k < 8; k++) begin
         wdata = base + DW'(k);
         idle(1);
      end
      if (!ignored) begin
         for (int k = 0; k < (single ? 1 : bl); k++) model[wcol(col, k, bl)] = base + DW'(k);
      end
      idle(3);
   endtask

   task automatic read_burst(input int col, input int bl, input int lat, input string tag);
      cmd = 2'b10; addr = AW'(col);
      idle(1);
      cmd = 2'b00;
      check({tag, " R4 drive before n+lat-1"}, dq_oe, 0);
      for (int j = 1; j <= lat + bl + 1; j++) begin
         idle(1);
         check({tag, " R2 R3 valid timing"}, rvalid, (j >= lat && j < lat + bl) ? 1 : 0);
         check({tag, " R4 R5 drive timing"}, dq_oe, (j >= lat - 1 && j < lat + bl) ? 1 : 0);
         if (j >= lat && j < lat + bl)
            check({tag, " R6 R7 data"}, rdata, model[wcol(col, j - lat, bl)]);
      end
      idle(2);
   endtask

   task automatic read_blocked(input int col);
      cmd = 2'b10; addr = AW'(col);
      idle(1);
      cmd = 2'b00;
      for (int j = 0; j < 8; j++) begin
         check("R12 no drive under error", dq_oe, 0);
         check("R12 no data under error", rvalid, 0);
         idle(1);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 rvalid after reset", rvalid, 0);
      check("R1 dq_oe after reset", dq_oe, 0);
      check("R1 mode_err after reset", mode_err, 0);
      idle(1);

      // defaults: one beat, latency two
      write_burst(3, 16'h1111, 1, 1'b0, 1'b0);
      read_burst(3, 1, 2, "R1 default");

      // fill the array with eight-beat writes
      load_mode(3'b011, 3'b010, 2'b00, 1'b0);
      check("R13 legal mode", mode_err, 0);
      write_burst(0, 16'hA000, 8, 1'b0, 1'b0);
      write_burst(8, 16'hB000, 8, 1'b0, 1'b0);
      read_burst(0, 8, 2, "R8 fill low");

      // table of read vectors
      for (int i = 0; i < 8; i++) begin
         load_mode(VEC[i][12:10], {1'b0, VEC[i][9:8]}, 2'b00, 1'b0);
         read_burst(int'(VEC[i][7:4]), int'(VEC[i][3:0]), int'(VEC[i][9:8]), "R6 table");
      end

      // short write burst wraps inside its pair
      load_mode(3'b001, 3'b010, 2'b00, 1'b0);
      write_burst(7, 16'hD000, 2, 1'b0, 1'b0);
      read_burst(6, 2, 2, "R8 R7 two-beat write");

      // single-location writes, reads still burst
      load_mode(3'b010, 3'b011, 2'b00, 1'b1);
      write_burst(13, 16'hC000, 4, 1'b1, 1'b0);
      read_burst(12, 4, 3, "R9 single write");

      // illegal latency code
      load_mode(3'b010, 3'b101, 2'b00, 1'b0);
      check("R10 bad latency flags error", mode_err, 1);
      read_blocked(0);
      write_burst(0, 16'hEEEE, 8, 1'b0, 1'b1);
      load_mode(3'b011, 3'b010, 2'b00, 1'b0);
      check("R13 error cleared", mode_err, 0);
      read_burst(0, 8, 2, "R12 write ignored");

      // another illegal latency code
      load_mode(3'b000, 3'b001, 2'b00, 1'b0);
      check("R10 latency code 001 flags error", mode_err, 1);

      // non-normal operating mode
      load_mode(3'b000, 3'b011, 2'b01, 1'b0);
      check("R11 op 01 flags error", mode_err, 1);
      read_blocked(5);
      load_mode(3'b000, 3'b011, 2'b10, 1'b0);
      check("R11 op 10 flags error", mode_err, 1);
      load_mode(3'b001, 3'b011, 2'b00, 1'b0);
      check("R13 error cleared again", mode_err, 0);
      read_burst(9, 2, 3, "R13 fields applied");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule